// File: doc/BRIEF.md
# Memory-Side Atomic Reservation Unit

This block sits beside one memory cache bank and serves single-word atomic operations for many requesters. Commands arrive as packets of 32-bit flits, one flit per accepted cycle, each carrying a transaction identifier and a packet identifier. A linked load reads a word and records a reservation: the word address paired with a fresh signature taken from a free-running counter. The signature goes back to the requester, which must present it with a later store conditional. A compare-and-swap is served by the same packet engine. An ordinary single-word write is accepted so that it cancels reservations on the word it overwrites.

Reservations live in a small table that is filled in round-robin order. A store conditional succeeds only while a live entry matches both its address and its signature. Any successful store to a word clears every reservation that names it. Responses carry a success/failure flag, or the loaded data and its signature, and echo the identifiers of their command. The unit handles one packet at a time: `cmdReady` stays low from the final command flit until the response has been sent.

Top module: `atom_resv_unit`

## Requirements
- R1: After reset `cmdReady` is 1, `rspValid` is 0, every storage word is 0, no reservation is live and the signature counter is 0.
- R2: A linked load (`cmdOp`=1) is one command flit. Its response is two flits: the stored word with `rspLast`=0, then the signature with `rspLast`=1.
- R3: Each linked load takes the current counter value as its signature, and the counter then steps by one. A failed or successful store does not move the counter.
- R4: A store conditional (`cmdOp`=2) is two flits: the new data, then the signature. When a live entry holds the same address and signature, the data is written, every entry for that address is cleared, and the flag is 0.
- R5: A store conditional with no matching live entry, whether the address or the signature differs, writes nothing and returns flag 1.
- R6: A compare-and-swap (`cmdOp`=3) is two flits: the expected old value, then the new value. It writes the new value and returns flag 0 only when the stored word equals the old value. Otherwise it writes nothing and returns flag 1.
- R7: A successful compare-and-swap clears every reservation on its word.
- R8: A plain write (`cmdOp`=0) is one flit. It stores the data, clears every reservation on that word, and answers with a single flit of value 0.
- R9: The table holds 4 reservations and replaces them in round-robin order, so the fifth linked load overwrites the reservation of the first.
- R10: Every response flit carries the `rspTrdId` and `rspPktId` of its command. Opcode, address and identifiers are taken from the first command flit only.
- R11: Flag responses are single flits with the flag in bit 0 (0 success, 1 failure) and bits 31:1 at 0.
- R12: `cmdReady` is 1 while a packet may be accepted, including the wait for a second flit. It is 0 from the edge that takes the final flit until the last response flit has left. No response flit appears at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | A command flit is present |
| cmdReady | output | 1 | The unit takes the flit on this edge |
| cmdOp | input | 2 | Operation: 0 write, 1 linked load, 2 store conditional, 3 compare-and-swap (first flit only) |
| cmdAddr | input | ADDR_W | Word address (first flit only) |
| cmdData | input | 32 | Flit payload |
| cmdTrdId | input | TRD_W | Transaction identifier (first flit only) |
| cmdPktId | input | PKT_W | Packet identifier (first flit only) |
| rspValid | output | 1 | A response flit is present |
| rspData | output | 32 | Response payload |
| rspLast | output | 1 | Final flit of the response |
| rspTrdId | output | TRD_W | Echoed transaction identifier |
| rspPktId | output | PKT_W | Echoed packet identifier |

## Verification
The edge that takes the final command flit starts one execute cycle. The first response flit is therefore visible in the cycle that follows the next edge, and a linked load's signature flit comes one cycle after that. The bench counts clock edges and tags each predicted flit with the edge count at which it is due. On every falling edge it compares the outputs against the head of that queue, or requires `rspValid` to be low when nothing is due. The bench derives `cmdReady` timing from the same edge count, so a response that comes early or late fails even when its payload is right.

// File: rtl/atom_pkg.sv
package atom_pkg;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_LL    = 2'd1,
    OP_SC    = 2'd2,
    OP_CAS   = 2'd3
  } atom_op_e;

  // strobes from control to datapath
  typedef struct packed {
    logic takeHead;    // capture first flit and header
    logic takeSecond;  // capture second flit
    logic execute;     // perform the operation
    logic showSecond;  // present the second response word
  } atom_strobe_t;

endpackage

// File: rtl/atom_ctrl.sv
module atom_ctrl
  import atom_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cmdValid,
  input  logic [1:0]   cmdOp,
  output logic         cmdReady,
  output logic         rspValid,
  output logic         rspLast,
  output atom_strobe_t strobe
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT2, ST_EXEC, ST_SEND0, ST_SEND1
  } ctrl_state_e;

  ctrl_state_e state, stateNext;
  atom_op_e    opHeld;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      opHeld <= OP_WRITE;
    end else begin
      state <= stateNext;
      if (strobe.takeHead) opHeld <= atom_op_e'(cmdOp);
    end
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    cmdReady  = 1'b0;
    rspValid  = 1'b0;
    rspLast   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        cmdReady = 1'b1;
        if (cmdValid) begin
          strobe.takeHead = 1'b1;
          if (cmdOp == OP_SC || cmdOp == OP_CAS) stateNext = ST_WAIT2;
          else                                   stateNext = ST_EXEC;
        end
      end
      ST_WAIT2: begin
        cmdReady = 1'b1;
        if (cmdValid) begin
          strobe.takeSecond = 1'b1;
          stateNext = ST_EXEC;
        end
      end
      ST_EXEC: begin
        strobe.execute = 1'b1;
        stateNext = ST_SEND0;
      end
      ST_SEND0: begin
        rspValid  = 1'b1;
        rspLast   = (opHeld != OP_LL);
        stateNext = (opHeld == OP_LL) ? ST_SEND1 : ST_IDLE;
      end
      ST_SEND1: begin
        rspValid          = 1'b1;
        rspLast           = 1'b1;
        strobe.showSecond = 1'b1;
        stateNext         = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/atom_datapath.sv
module atom_datapath
  import atom_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int SLOTS  = 4,
  parameter int TRD_W  = 4,
  parameter int PKT_W  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  atom_strobe_t       strobe,
  input  logic [1:0]         cmdOp,
  input  logic [ADDR_W-1:0]  cmdAddr,
  input  logic [31:0]        cmdData,
  input  logic [TRD_W-1:0]   cmdTrdId,
  input  logic [PKT_W-1:0]   cmdPktId,
  output logic [31:0]        rspData,
  output logic [TRD_W-1:0]   rspTrdId,
  output logic [PKT_W-1:0]   rspPktId
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int SW    = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  atom_op_e          hdrOp;
  logic [ADDR_W-1:0] hdrAddr;
  logic [31:0]       flitA, flitB;
  logic [31:0]       memArr [DEPTH];
  logic [SLOTS-1:0]  slotValid;
  logic [ADDR_W-1:0] slotAddr [SLOTS];
  logic [31:0]       slotSig  [SLOTS];
  logic [SW-1:0]     rrPtr;
  logic [31:0]       sigCount;
  logic [31:0]       word0, word1;

  // header and payload capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hdrOp    <= OP_WRITE;
      hdrAddr  <= '0;
      rspTrdId <= '0;
      rspPktId <= '0;
      flitA    <= '0;
      flitB    <= '0;
    end else begin
      if (strobe.takeHead) begin
        hdrOp    <= atom_op_e'(cmdOp);
        hdrAddr  <= cmdAddr;
        rspTrdId <= cmdTrdId;
        rspPktId <= cmdPktId;
        flitA    <= cmdData;
      end
      if (strobe.takeSecond) flitB <= cmdData;
    end
  end

  // operation decision
  logic [31:0]      curWord;
  logic [SLOTS-1:0] addrHit, fullHit;
  logic             doStore, clearAddr, failFlag;
  logic [31:0]      storeVal, resWord0;

  assign curWord = memArr[hdrAddr];

  for (genvar s = 0; s < SLOTS; s++) begin : g_match
    assign addrHit[s] = slotValid[s] && (slotAddr[s] == hdrAddr);
    assign fullHit[s] = addrHit[s] && (slotSig[s] == flitB);
  end

  always_comb begin
    doStore  = 1'b0;
    storeVal = flitA;
    failFlag = 1'b0;
    resWord0 = '0;
    unique case (hdrOp)
      OP_WRITE: doStore = 1'b1;
      OP_LL:    resWord0 = curWord;
      OP_SC: begin
        doStore  = |fullHit;
        failFlag = ~doStore;
        resWord0 = {31'd0, failFlag};
      end
      OP_CAS: begin
        doStore  = (curWord == flitA);
        storeVal = flitB;
        failFlag = ~doStore;
        resWord0 = {31'd0, failFlag};
      end
      default: ;
    endcase
    clearAddr = doStore;
  end

  // storage array
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int w = 0; w < DEPTH; w++) memArr[w] <= '0;
    end else if (strobe.execute && doStore) begin
      memArr[hdrAddr] <= storeVal;
    end
  end

  // reservation table
  logic allocate;
  assign allocate = strobe.execute && (hdrOp == OP_LL);

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotValid[s] <= 1'b0;
        slotAddr[s]  <= '0;
        slotSig[s]   <= '0;
      end else if (allocate && rrPtr == SW'(s)) begin
        slotValid[s] <= 1'b1;
        slotAddr[s]  <= hdrAddr;
        slotSig[s]   <= sigCount;
      end else if (strobe.execute && clearAddr && addrHit[s]) begin
        slotValid[s] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rrPtr    <= '0;
      sigCount <= '0;
    end else if (allocate) begin
      rrPtr    <= (rrPtr == SW'(SLOTS - 1)) ? '0 : rrPtr + 1'b1;
      sigCount <= sigCount + 32'd1;
    end
  end

  // response words
  always_ff @(posedge clk) begin
    if (!rstN) begin
      word0 <= '0;
      word1 <= '0;
    end else if (strobe.execute) begin
      word0 <= resWord0;
      word1 <= sigCount;
    end
  end

  assign rspData = strobe.showSecond ? word1 : word0;

endmodule

// File: rtl/atom_resv_unit.sv
module atom_resv_unit
  import atom_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int SLOTS  = 4,
  parameter int TRD_W  = 4,
  parameter int PKT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [1:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [31:0]       cmdData,
  input  logic [TRD_W-1:0]  cmdTrdId,
  input  logic [PKT_W-1:0]  cmdPktId,
  output logic              rspValid,
  output logic [31:0]       rspData,
  output logic              rspLast,
  output logic [TRD_W-1:0]  rspTrdId,
  output logic [PKT_W-1:0]  rspPktId
);

  atom_strobe_t strobe;

  atom_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdOp    (cmdOp),
    .cmdReady (cmdReady),
    .rspValid (rspValid),
    .rspLast  (rspLast),
    .strobe   (strobe)
  );

  atom_datapath #(
    .ADDR_W (ADDR_W),
    .SLOTS  (SLOTS),
    .TRD_W  (TRD_W),
    .PKT_W  (PKT_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cmdOp    (cmdOp),
    .cmdAddr  (cmdAddr),
    .cmdData  (cmdData),
    .cmdTrdId (cmdTrdId),
    .cmdPktId (cmdPktId),
    .rspData  (rspData),
    .rspTrdId (rspTrdId),
    .rspPktId (rspPktId)
  );

endmodule

// File: rtl/atom_resv_checker.sv
module atom_resv_checker #(
  parameter int TRD_W = 4,
  parameter int PKT_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             cmdReady,
  input logic             rspValid,
  input logic             rspLast,
  input logic [31:0]      rspData,
  input logic [TRD_W-1:0] rspTrdId,
  input logic [PKT_W-1:0] rspPktId
);

  // R12: no acceptance while a response is leaving
  a_r12_busy_no_accept: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !cmdReady);

  // R12: a response starts only after a cycle with the request port closed
  a_r12_exec_gap: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rspValid) |-> !$past(cmdReady));

  // R2: a non-final flit is followed at once by the final one
  a_r2_two_flit_tail: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspLast) |=> (rspValid && rspLast));

  // R10: identifiers held across a two-flit response
  a_r10_ids_held: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspLast) |=> ($stable(rspTrdId) && $stable(rspPktId)));

  // R11: single-flit responses carry only bit 0
  a_r11_flag_bits: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspLast && !$past(rspValid)) |-> (rspData[31:1] == 31'd0));

endmodule

bind atom_resv_unit atom_resv_checker #(.TRD_W(TRD_W), .PKT_W(PKT_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cmdReady (cmdReady),
  .rspValid (rspValid),
  .rspLast  (rspLast),
  .rspData  (rspData),
  .rspTrdId (rspTrdId),
  .rspPktId (rspPktId)
);

// File: tb/atom_resv_unit_tb.sv
module atom_resv_unit_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic        cmdReady;
  logic [1:0]  cmdOp = '0;
  logic [3:0]  cmdAddr = '0;
  logic [31:0] cmdData = '0;
  logic [3:0]  cmdTrdId = '0;
  logic [3:0]  cmdPktId = '0;
  logic        rspValid;
  logic [31:0] rspData;
  logic        rspLast;
  logic [3:0]  rspTrdId;
  logic [3:0]  rspPktId;

  atom_resv_unit u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdOp(cmdOp), .cmdAddr(cmdAddr), .cmdData(cmdData),
    .cmdTrdId(cmdTrdId), .cmdPktId(cmdPktId),
    .rspValid(rspValid), .rspData(rspData), .rspLast(rspLast),
    .rspTrdId(rspTrdId), .rspPktId(rspPktId)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit running = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // reference model state
  logic [31:0] refMem [16];
  bit          refValid [4];
  int          refAddr [4];
  logic [31:0] refSig [4];
  int          refPtr = 0;
  logic [31:0] refCount = '0;
  int          tagSeq = 0;
  logic [31:0] lastSig;

  typedef struct {
    int          due;
    logic [31:0] data;
    logic        last;
    logic [3:0]  trd;
    logic [3:0]  pkt;
    string       req;
  } exp_t;
  exp_t expQ [$];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // compared on every falling edge
  always @(negedge clk) begin
    if (running) begin
      if (expQ.size() > 0 && expQ[0].due == cyc) begin
        check(rspValid === 1'b1, "R12", "rspValid due", {31'd0, rspValid}, 32'd1);
        check(rspData === expQ[0].data, expQ[0].req, "rspData", rspData, expQ[0].data);
        check(rspLast === expQ[0].last, expQ[0].req, "rspLast", {31'd0, rspLast}, {31'd0, expQ[0].last});
        check(rspTrdId === expQ[0].trd && rspPktId === expQ[0].pkt, "R10", "ids",
              {24'd0, rspTrdId, rspPktId}, {24'd0, expQ[0].trd, expQ[0].pkt});
        void'(expQ.pop_front());
      end else begin
        check(rspValid === 1'b0, "R12", "rspValid idle", {31'd0, rspValid}, 32'd0);
      end
    end
  end

  function automatic void pushExp(input int due, input logic [31:0] d, input logic l,
                                  input logic [3:0] t, input logic [3:0] p, input string r);
    exp_t e;
    e.due = due; e.data = d; e.last = l; e.trd = t; e.pkt = p; e.req = r;
    expQ.push_back(e);
  endfunction

  function automatic void refClear(input int addr);
    for (int i = 0; i < 4; i++) if (refValid[i] && refAddr[i] == addr) refValid[i] = 1'b0;
  endfunction

  task automatic sendCmd(input int op, input int addr, input logic [31:0] d0,
                         input logic [31:0] d1, input int gap, input string req);
    logic [3:0] t, p;
    int a;
    bit ok;
    t = 4'(tagSeq); p = 4'(tagSeq * 7 + 3); tagSeq++;
    check(cmdReady === 1'b1, "R12", "ready before command", {31'd0, cmdReady}, 32'd1);
    cmdValid = 1'b1; cmdOp = 2'(op); cmdAddr = 4'(addr); cmdData = d0;
    cmdTrdId = t; cmdPktId = p;
    @(posedge clk); @(negedge clk);
    if (op >= 2) begin
      cmdOp = 2'(~op); cmdAddr = 4'(addr + 1); cmdTrdId = ~t; cmdPktId = ~p;  // R10: ignored
      if (gap > 0) begin
        cmdValid = 1'b0;
        for (int g = 0; g < gap; g++) begin
          check(cmdReady === 1'b1, "R12", "ready waiting second flit", {31'd0, cmdReady}, 32'd1);
          @(negedge clk);
        end
        cmdValid = 1'b1;
      end
      cmdData = d1;
      @(posedge clk); @(negedge clk);
    end
    cmdValid = 1'b0;
    a = cyc;
    check(cmdReady === 1'b0, "R12", "busy after final flit", {31'd0, cmdReady}, 32'd0);
    case (op)
      0: begin
        refMem[addr] = d0; refClear(addr);
        pushExp(a + 1, 32'd0, 1'b1, t, p, req);
      end
      1: begin
        pushExp(a + 1, refMem[addr], 1'b0, t, p, req);
        pushExp(a + 2, refCount, 1'b1, t, p, req);
        lastSig = refCount;
        refValid[refPtr] = 1'b1; refAddr[refPtr] = addr; refSig[refPtr] = refCount;
        refPtr = (refPtr + 1) % 4; refCount = refCount + 1;
      end
      2: begin
        ok = 1'b0;
        for (int i = 0; i < 4; i++) if (refValid[i] && refAddr[i] == addr && refSig[i] == d1) ok = 1'b1;
        if (ok) begin refMem[addr] = d0; refClear(addr); end
        pushExp(a + 1, {31'd0, ~ok}, 1'b1, t, p, req);
      end
      default: begin
        ok = (refMem[addr] == d0);
        if (ok) begin refMem[addr] = d1; refClear(addr); end
        pushExp(a + 1, {31'd0, ~ok}, 1'b1, t, p, req);
      end
    endcase
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  logic [31:0] s0, s1, s2;

  initial begin
    for (int i = 0; i < 16; i++) refMem[i] = '0;
    for (int i = 0; i < 4; i++) begin refValid[i] = 1'b0; refAddr[i] = 0; refSig[i] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(cmdReady === 1'b1, "R1", "reset ready", {31'd0, cmdReady}, 32'd1);
    check(rspValid === 1'b0, "R1", "reset rspValid", {31'd0, rspValid}, 32'd0);
    running = 1'b1;

    sendCmd(1, 2, 0, 0, 0, "R1");                 // zero word, signature 0
    sendCmd(0, 3, 32'h0000_A5A5, 0, 0, "R8");
    sendCmd(1, 3, 0, 0, 0, "R2");
    s0 = lastSig;
    sendCmd(2, 3, 32'h1111_0000, s0, 0, "R4");    // success
    sendCmd(2, 3, 32'h2222_0000, s0, 0, "R4");    // reservation gone
    sendCmd(1, 3, 0, 0, 0, "R3");
    s1 = lastSig;
    sendCmd(0, 3, 32'h3333_3333, 0, 0, "R8");     // write cancels
    sendCmd(2, 3, 32'h4444_4444, s1, 0, "R8");    // fails
    sendCmd(1, 3, 0, 0, 0, "R8");                 // read back 3333_3333

    sendCmd(1, 5, 0, 0, 0, "R3");
    s2 = lastSig;
    sendCmd(2, 5, 32'h5555_5555, s2 + 9, 0, "R5"); // wrong signature
    sendCmd(2, 6, 32'h5555_5555, s2, 0, "R5");     // wrong address
    sendCmd(1, 6, 0, 0, 0, "R5");                  // still zero
    sendCmd(2, 5, 32'h0000_0055, s2, 2, "R4");     // gap between flits
    sendCmd(3, 5, 32'h0000_0055, 32'h66, 0, "R6"); // match
    sendCmd(3, 5, 32'h0000_0055, 32'h77, 1, "R6"); // mismatch
    sendCmd(1, 5, 0, 0, 0, "R6");                  // reads 66

    sendCmd(1, 7, 0, 0, 0, "R7");
    s0 = lastSig;
    sendCmd(3, 7, 32'h0, 32'h9, 0, "R7");
    sendCmd(2, 7, 32'hDEAD_BEEF, s0, 0, "R7");     // cleared by swap

    sendCmd(1, 8, 0, 0, 0, "R9");
    s0 = lastSig;
    sendCmd(1, 9, 0, 0, 0, "R9");
    s1 = lastSig;
    sendCmd(1, 10, 0, 0, 0, "R9");
    sendCmd(1, 11, 0, 0, 0, "R9");
    sendCmd(1, 12, 0, 0, 0, "R9");                 // evicts address 8
    sendCmd(2, 8, 32'h8888_8888, s0, 0, "R9");
    sendCmd(2, 9, 32'h9999_9999, s1, 0, "R9");
    sendCmd(1, 9, 0, 0, 0, "R11");
    sendCmd(0, 15, 32'hFFFF_FFFF, 0, 0, "R11");
    sendCmd(3, 15, 32'hFFFF_FFFE, 32'h1, 0, "R11");

    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R12", "all responses seen", expQ.size(), 0);
    running = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule